// File: doc/BRIEF.md
# Byte-Wise I2C Target Engine with Host Handshake

This block lets a host processor take part in I2C traffic as a target device. It samples the bus through a synchroniser running on the system clock, finds START and STOP conditions, and compares the first byte after each START with a programmed 7-bit own address. It then moves data one byte per host handshake. Every bus event is reported as a sticky status bit, and each bit can feed a level interrupt.

A received byte is acknowledged and placed in a byte buffer. The engine then holds SCL low until the host has cleared the receive flag. When the master reads, the engine also keeps SCL low until the host has loaded a byte and issued a transmit command. Only then is the byte shifted out, most significant bit first. The master's acknowledge or not-acknowledge is reported. After a not-acknowledge the engine stays off the bus until the next START or STOP.

Top module: `i2c_target_ctrl`

## Requirements
- R1: Bit 1 of the control register (offset 0x00) enables the target. Bit 0 of that register is stored but has no effect. While bit 1 is clear, no address is acknowledged, no status bit is set, and neither SDA nor SCL is driven.
- R2: Bits [6:0] of the own-address register (offset 0x18) select the address that is answered. The other bits of that register do not change which address matches.
- R3: When the address byte carries the own address, the engine drives SDA low in the acknowledge slot and sets status bit 7. Any other address gets no acknowledge and sets no status bit.
- R4: Every acknowledged byte, the address byte included, sets status bit 2 and appears in bits [15:8] of the byte buffer (offset 0x20). For the address byte, bit 8 is the R/W bit (1 = master read). Data bytes written by the master are always acknowledged.
- R5: After the acknowledge slot of a received byte, SCL is held low for as long as status bit 2 is set. SCL is released once that bit is clear.
- R6: After a read address is acknowledged, SCL stays low until the host writes 1 to bit 1 of the command register (offset 0x14). Clearing status bit 2 does not release it. The byte in bits [7:0] of the byte buffer is then sent MSB first.
- R7: An acknowledge from the master after a sent byte sets status bit 0. SCL is then held low again until the next transmit command.
- R8: A not-acknowledge from the master sets status bit 1. After it the engine drives SDA for nothing, transmit commands included, until a STOP or a START.
- R9: A STOP after an own-address match sets status bit 4. The engine then goes idle and answers nothing until a new START carries a matching address.
- R10: The status register (offset 0x10) clears each bit written with 1. Bits written with 0 keep their value, and several bits clear in one write. When a bus event sets a bit in the same cycle as a write clears it, the bit ends set.
- R11: The irq output is high exactly when some status bit is set and its bit in the interrupt-enable register (offset 0x0C) is set.
- R12: After reset the status and interrupt-enable registers are zero, irq is low, and SDA and SCL are released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| scl_i | input | 1 | SCL level seen on the bus |
| scl_oe | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_i | input | 1 | SDA level seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low |
| irq | output | 1 | Level interrupt |

## Verification
Two of this block's functions can act on the receive-done bit in the same clock cycle: the bus engine setting it at the end of a byte, and a host write-one clear. The bench times the falling SCL edge of the eighth data bit against the two-stage synchroniser and the edge detector. It then places a clearing register write in exactly the cycle in which the engine registers the byte. The result is judged from outside. The bit must read back as set, and SCL must stay held low until a later clear. The other sweeps run every 7-bit bus address against one programmed address, and cover reads that end in an acknowledge and in a not-acknowledge.

// File: rtl/i2ct_pkg.sv
`timescale 1ns/1ps
package i2ct_pkg;
  // register byte offsets
  localparam int OFS_FUNC  = 'h00;
  localparam int OFS_IRQEN = 'h0C;
  localparam int OFS_STAT  = 'h10;
  localparam int OFS_CMD   = 'h14;
  localparam int OFS_OWN   = 'h18;
  localparam int OFS_BYTE  = 'h20;

  // control and command bit positions
  localparam int FUNC_TGT_BIT = 1;
  localparam int FUNC_CTL_BIT = 0;
  localparam int CMD_TX_BIT   = 1;

  // status bit positions
  localparam int ST_TXACK  = 0;
  localparam int ST_TXNAK  = 1;
  localparam int ST_RXDONE = 2;
  localparam int ST_STOP   = 4;
  localparam int ST_MATCH  = 7;
  localparam int STAT_W    = 8;

  localparam int BYTE_W = 8;
  localparam int TGT_AW = 7;

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_RXDAT, S_ACK, S_RXWAIT,
    S_TXWAIT, S_TXSET, S_TXDAT, S_TXACK, S_IGNORE
  } eng_state_t;

  function automatic logic addr_hit(input logic [BYTE_W-1:0] frame,
                                    input logic [TGT_AW-1:0] own);
    return frame[BYTE_W-1:1] == own;
  endfunction

  function automatic logic [STAT_W-1:0] w1c_update(input logic [STAT_W-1:0] cur,
                                                   input logic [STAT_W-1:0] setv,
                                                   input logic [STAT_W-1:0] clrv);
    return (cur & ~clrv) | setv;
  endfunction
endpackage

// File: rtl/i2ct_sync.sv
`timescale 1ns/1ps
module i2ct_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_p, sda_p;

  generate
    if (STAGES > 1) begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_q <= '1;
          sda_q <= '1;
        end else begin
          scl_q <= {scl_q[STAGES-2:0], scl_in};
          sda_q <= {sda_q[STAGES-2:0], sda_in};
        end
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_q <= '1;
          sda_q <= '1;
        end else begin
          scl_q <= scl_in;
          sda_q <= sda_in;
        end
      end
    end
  endgenerate

  assign scl_s = scl_q[STAGES-1];
  assign sda_s = sda_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  assign scl_rise = ~scl_p & scl_s;
  assign scl_fall = scl_p & ~scl_s;
  assign start_ev = scl_p & scl_s & sda_p & ~sda_s;
  assign stop_ev  = scl_p & scl_s & ~sda_p & sda_s;
endmodule

// File: rtl/i2ct_engine.sv
`timescale 1ns/1ps
module i2ct_engine
  import i2ct_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tgt_en,
  input  logic [TGT_AW-1:0] own_addr,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic              rx_pending,
  input  logic              tx_cmd,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic              ev_match,
  output logic              ev_rx,
  output logic              ev_txack,
  output logic              ev_txnak,
  output logic              ev_stop,
  output logic [BYTE_W-1:0] rx_data,
  output logic              sda_drive,
  output logic              scl_hold
);
  localparam int CW = $clog2(BYTE_W + 1);

  eng_state_t        state;
  logic [BYTE_W-1:0] shift;
  logic [CW-1:0]     cnt;
  logic              is_rd, engaged, got_ack, nak_hold;
  logic              quiet, byte_done, hit;

  assign quiet     = tgt_en & ~stop_ev & ~start_ev;
  assign byte_done = (state == S_ADDR || state == S_RXDAT) && scl_fall && cnt == CW'(BYTE_W);
  assign hit       = addr_hit(shift, own_addr);

  assign ev_match = quiet & byte_done & (state == S_ADDR) & hit;
  assign ev_rx    = quiet & byte_done & ((state == S_RXDAT) | hit);
  assign ev_txack = quiet & (state == S_TXACK) & scl_rise & ~sda_s;
  assign ev_txnak = quiet & (state == S_TXACK) & scl_rise & sda_s;
  assign ev_stop  = tgt_en & stop_ev & engaged;
  assign rx_data  = shift;

  assign sda_drive = (state == S_ACK) |
                     (((state == S_TXSET) | (state == S_TXDAT)) & ~shift[BYTE_W-1]);
  assign scl_hold  = (state == S_RXWAIT) | (state == S_TXWAIT) | (state == S_TXSET);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      shift   <= '0;
      cnt     <= '0;
      is_rd   <= 1'b0;
      engaged <= 1'b0;
      got_ack <= 1'b0;
    end else if (!tgt_en) begin
      state   <= S_IDLE;
      cnt     <= '0;
      engaged <= 1'b0;
    end else if (stop_ev) begin
      state   <= S_IDLE;
      engaged <= 1'b0;
    end else if (start_ev) begin
      state   <= S_ADDR;
      cnt     <= '0;
      is_rd   <= 1'b0;
      engaged <= 1'b0;
    end else begin
      case (state)
        S_ADDR, S_RXDAT: begin
          if (scl_rise) begin
            shift <= {shift[BYTE_W-2:0], sda_s};
            cnt   <= cnt + 1'b1;
          end else if (byte_done) begin
            if (state == S_RXDAT || hit) begin
              state <= S_ACK;
              if (state == S_ADDR) begin
                is_rd   <= shift[0];
                engaged <= 1'b1;
              end
            end else begin
              state <= S_IGNORE;
            end
          end
        end
        S_ACK: if (scl_fall) state <= is_rd ? S_TXWAIT : S_RXWAIT;
        S_RXWAIT: if (!rx_pending) begin
          state <= S_RXDAT;
          cnt   <= '0;
        end
        S_TXWAIT: if (tx_cmd) begin
          shift <= tx_byte;
          cnt   <= '0;
          state <= S_TXSET;
        end
        S_TXSET: state <= S_TXDAT;
        S_TXDAT: if (scl_fall) begin
          if (cnt == CW'(BYTE_W - 1)) begin
            state <= S_TXACK;
          end else begin
            shift <= {shift[BYTE_W-2:0], 1'b0};
            cnt   <= cnt + 1'b1;
          end
        end
        S_TXACK: begin
          if (scl_rise) got_ack <= ~sda_s;
          if (scl_fall) state <= got_ack ? S_TXWAIT : S_IGNORE;
        end
        default: ;
      endcase
    end
  end

  // records that the master refused data; cleared by any bus boundary
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) nak_hold <= 1'b0;
    else if (!tgt_en || stop_ev || start_ev) nak_hold <= 1'b0;
    else if (ev_txnak) nak_hold <= 1'b1;
  end

  a_r1_off_releases_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !tgt_en |=> (!sda_drive && !scl_hold));
  a_r3_match_drives_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ev_match |=> sda_drive);
  a_r5_hold_while_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RXWAIT && rx_pending && quiet) |=> scl_hold);
  a_r6_hold_until_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_TXWAIT && !tx_cmd && quiet) |=> scl_hold);
  a_r8_silent_after_nak: assert property (@(posedge clk) disable iff (!rst_n)
    nak_hold |-> !sda_drive);
endmodule

// File: rtl/i2ct_regs.sv
`timescale 1ns/1ps
module i2ct_regs
  import i2ct_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [AW-1:0]     reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic [STAT_W-1:0] set_vec,
  input  logic              rx_load,
  input  logic [BYTE_W-1:0] rx_byte_in,
  output logic              tgt_en,
  output logic [TGT_AW-1:0] own_addr,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              tx_cmd,
  output logic              rx_pending,
  output logic              irq
);
  logic [1:0]        func_q;
  logic [STAT_W-1:0] irqen_q, status_q, clr_mask;
  logic [TGT_AW-1:0] own_q;
  logic [BYTE_W-1:0] tx_q, rx_q;
  logic              stat_wr;

  assign stat_wr  = reg_we && reg_addr == AW'(OFS_STAT);
  assign clr_mask = stat_wr ? reg_wdata[STAT_W-1:0] : '0;
  assign tx_cmd   = reg_we && reg_addr == AW'(OFS_CMD) && reg_wdata[CMD_TX_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      func_q  <= '0;
      irqen_q <= '0;
      own_q   <= '0;
      tx_q    <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        AW'(OFS_FUNC):  func_q  <= reg_wdata[1:0];
        AW'(OFS_IRQEN): irqen_q <= reg_wdata[STAT_W-1:0];
        AW'(OFS_OWN):   own_q   <= reg_wdata[TGT_AW-1:0];
        AW'(OFS_BYTE):  tx_q    <= reg_wdata[BYTE_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      rx_q     <= '0;
    end else begin
      status_q <= w1c_update(status_q, set_vec, clr_mask);
      if (rx_load) rx_q <= rx_byte_in;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      AW'(OFS_FUNC):  reg_rdata[1:0] = func_q;
      AW'(OFS_IRQEN): reg_rdata[STAT_W-1:0] = irqen_q;
      AW'(OFS_STAT):  reg_rdata[STAT_W-1:0] = status_q;
      AW'(OFS_OWN):   reg_rdata[TGT_AW-1:0] = own_q;
      AW'(OFS_BYTE):  reg_rdata[2*BYTE_W-1:0] = {rx_q, tx_q};
      default: ;
    endcase
  end

  assign tgt_en     = func_q[FUNC_TGT_BIT];
  assign own_addr   = own_q;
  assign tx_byte    = tx_q;
  assign rx_pending = status_q[ST_RXDONE];
  assign irq        = |(status_q & irqen_q);

  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((status_q & $past(set_vec)) == $past(set_vec)));
  a_r10_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_mask & ~set_vec) != '0) |=> ((status_q & $past(clr_mask & ~set_vec)) == '0));
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_wr && set_vec == '0) |=> $stable(status_q));
endmodule

// File: rtl/i2c_target_ctrl.sv
`timescale 1ns/1ps
module i2c_target_ctrl
  import i2ct_pkg::*;
#(
  parameter int AW          = 8,
  parameter int DW          = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          scl_i,
  output logic          scl_oe,
  input  logic          sda_i,
  output logic          sda_oe,
  output logic          irq
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic tgt_en, tx_cmd, rx_pending;
  logic ev_match, ev_rx, ev_txack, ev_txnak, ev_stop;
  logic [TGT_AW-1:0] own_addr;
  logic [BYTE_W-1:0] tx_byte, rx_data;
  logic [STAT_W-1:0] set_vec;

  i2ct_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_i), .sda_in(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev));

  i2ct_engine u_engine (
    .clk(clk), .rst_n(rst_n), .tgt_en(tgt_en), .own_addr(own_addr),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev), .rx_pending(rx_pending),
    .tx_cmd(tx_cmd), .tx_byte(tx_byte), .ev_match(ev_match), .ev_rx(ev_rx),
    .ev_txack(ev_txack), .ev_txnak(ev_txnak), .ev_stop(ev_stop),
    .rx_data(rx_data), .sda_drive(sda_oe), .scl_hold(scl_oe));

  always_comb begin
    set_vec            = '0;
    set_vec[ST_MATCH]  = ev_match;
    set_vec[ST_RXDONE] = ev_rx;
    set_vec[ST_TXACK]  = ev_txack;
    set_vec[ST_TXNAK]  = ev_txnak;
    set_vec[ST_STOP]   = ev_stop;
  end

  i2ct_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .set_vec(set_vec),
    .rx_load(ev_rx), .rx_byte_in(rx_data), .tgt_en(tgt_en),
    .own_addr(own_addr), .tx_byte(tx_byte), .tx_cmd(tx_cmd),
    .rx_pending(rx_pending), .irq(irq));

  a_r9_stop_needs_bus_stop: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |-> (scl_s && sda_s));
endmodule

// File: tb/i2c_target_ctrl_bench.sv
`timescale 1ns/1ps
module i2c_target_ctrl_bench;
  localparam int HALF = 8;
  localparam logic [6:0] OWN = 7'h2A;
  localparam logic [7:0] A_FUNC = 8'h00, A_IRQEN = 8'h0C, A_STAT = 8'h10,
                         A_CMD = 8'h14, A_OWN = 8'h18, A_BYTE = 8'h20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic scl_oe, sda_oe, irq, scl_bus, sda_bus;
  logic m_scl_low = 1'b0, m_sda_low = 1'b0;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  assign scl_bus = ~(m_scl_low | scl_oe);
  assign sda_bus = ~(m_sda_low | sda_oe);

  i2c_target_ctrl u_i2c_target_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .scl_i(scl_bus),
    .scl_oe(scl_oe), .sda_i(sda_bus), .sda_oe(sda_oe), .irq(irq));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic scl_up();
    m_scl_low = 1'b0;
    do @(negedge clk); while (!scl_bus);
  endtask

  // one bit clock: scl low at entry and exit; returns SDA seen mid-high
  task automatic m_bit(input logic b, output logic s);
    wait_n(HALF/2);
    m_sda_low = ~b;
    wait_n(HALF/2);
    scl_up();
    wait_n(HALF/2);
    s = sda_bus;
    wait_n(HALF/2);
    m_scl_low = 1'b1;
  endtask

  task automatic m_start();
    wait_n(HALF/2);
    m_sda_low = 1'b0;
    wait_n(HALF/2);
    scl_up();
    wait_n(HALF);
    m_sda_low = 1'b1;
    wait_n(HALF);
    m_scl_low = 1'b1;
  endtask

  task automatic m_stop();
    wait_n(HALF/2);
    m_sda_low = 1'b1;
    wait_n(HALF/2);
    scl_up();
    wait_n(HALF);
    m_sda_low = 1'b0;
    wait_n(HALF);
  endtask

  // collide: clear receive-done in the very cycle the 8th falling edge is registered
  task automatic m_write_byte(input logic [7:0] v, input logic collide, output logic ack_n);
    logic s;
    for (int i = 7; i >= 0; i--) m_bit(v[i], s);
    if (collide) begin
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = A_STAT; reg_wdata = 32'h4;
      @(negedge clk);
      reg_we = 1'b0;
    end
    m_bit(1'b1, ack_n);
  endtask

  task automatic m_read_byte(output logic [7:0] v);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      m_bit(1'b1, s);
      v[i] = s;
    end
  endtask

  logic [31:0] rd;
  logic ack_n, s;
  logic [7:0] data;
  logic [7:0] wr_vals [5] = '{8'h5A, 8'hA5, 8'h00, 8'hFF, 8'h81};

  initial begin
    wait_n(5);
    rst_n = 1'b1;
    wait_n(2);
    reg_rd(A_STAT, rd);
    chk("R12 status after reset", rd, 32'h0);
    chk("R12 pins after reset", {29'b0, irq, scl_oe, sda_oe}, 32'h0);

    // R1: only the control bit set, target off
    reg_wr(A_OWN, 32'hFFFF_FF80 | 32'(OWN));
    reg_wr(A_FUNC, 32'h1);
    m_start();
    m_write_byte({OWN, 1'b0}, 1'b0, ack_n);
    m_stop();
    chk("R1 disabled gives no ack", {31'b0, ack_n}, 32'h1);
    reg_rd(A_STAT, rd);
    chk("R1 disabled sets no status", rd, 32'h0);

    // R2/R3/R9/R10: sweep every bus address against one own address
    reg_wr(A_FUNC, 32'h3);
    for (int b = 0; b < 128; b++) begin
      logic hit;
      hit = (7'(b) == OWN);
      m_start();
      m_write_byte({7'(b), 1'b0}, 1'b0, ack_n);
      chk(hit ? "R3 own address acked" : "R2 other address not acked",
          {31'b0, ack_n}, {31'b0, ~hit});
      if (!ack_n) begin
        reg_rd(A_BYTE, rd);
        chk("R4 address byte in buffer", {16'b0, rd[15:8], 8'b0}, {16'b0, 7'(b), 1'b0, 8'b0});
        reg_wr(A_STAT, 32'h4);
      end
      m_stop();
      reg_rd(A_STAT, rd);
      chk("R9 status after stop", rd, hit ? 32'h90 : 32'h0);
      if (hit) begin
        reg_wr(A_STAT, 32'hFF);
        reg_rd(A_STAT, rd);
        chk("R10 multi-bit clear", rd, 32'h0);
      end
    end

    // write transfer with interrupt mask and a same-cycle set/clear
    reg_wr(A_IRQEN, 32'h80);
    m_start();
    m_write_byte({OWN, 1'b0}, 1'b0, ack_n);
    chk("R3 write address acked", {31'b0, ack_n}, 32'h0);
    wait_n(5);
    chk("R11 irq on enabled match", {31'b0, irq}, 32'h1);
    reg_wr(A_STAT, 32'h0);
    reg_rd(A_STAT, rd);
    chk("R10 zero write keeps bits", rd, 32'h84);
    reg_wr(A_STAT, 32'h80);
    reg_rd(A_STAT, rd);
    chk("R10 single clear", rd, 32'h04);
    chk("R11 irq low with masked bit", {31'b0, irq}, 32'h0);
    reg_wr(A_STAT, 32'h04);
    for (int k = 0; k < 5; k++) begin
      m_write_byte(wr_vals[k], k == 2, ack_n);
      chk("R4 data byte acked", {31'b0, ack_n}, 32'h0);
      wait_n(6);
      chk("R5 scl held after byte", {31'b0, scl_oe}, 32'h1);
      reg_rd(A_STAT, rd);
      chk(k == 2 ? "R10 set wins same-cycle clear" : "R4 receive-done set", rd, 32'h04);
      reg_rd(A_BYTE, rd);
      chk("R4 data byte in buffer", {24'b0, rd[15:8]}, {24'b0, wr_vals[k]});
      reg_wr(A_STAT, 32'h04);
      wait_n(4);
      chk("R5 scl released after clear", {31'b0, scl_oe}, 32'h0);
    end
    m_stop();
    reg_rd(A_STAT, rd);
    chk("R9 stop after write", rd, 32'h10);
    reg_wr(A_STAT, 32'hFF);
    reg_wr(A_IRQEN, 32'h0);

    // read transfer: ack then nak
    m_start();
    m_write_byte({OWN, 1'b1}, 1'b0, ack_n);
    chk("R3 read address acked", {31'b0, ack_n}, 32'h0);
    reg_rd(A_BYTE, rd);
    chk("R4 read bit in buffer bit 8", {31'b0, rd[8]}, 32'h1);
    reg_wr(A_STAT, 32'hFF);
    wait_n(20);
    chk("R6 scl held without command", {31'b0, scl_oe}, 32'h1);
    reg_wr(A_BYTE, 32'hC3);
    reg_wr(A_CMD, 32'h2);
    m_read_byte(data);
    chk("R6 first byte sent msb first", {24'b0, data}, 32'hC3);
    m_bit(1'b0, s);
    reg_rd(A_STAT, rd);
    chk("R7 master ack recorded", rd, 32'h01);
    wait_n(4);
    chk("R7 scl held awaiting command", {31'b0, scl_oe}, 32'h1);
    reg_wr(A_STAT, 32'hFF);
    reg_wr(A_BYTE, 32'h3C);
    reg_wr(A_CMD, 32'h2);
    m_read_byte(data);
    chk("R6 second byte sent", {24'b0, data}, 32'h3C);
    m_bit(1'b1, s);
    reg_rd(A_STAT, rd);
    chk("R8 master nak recorded", rd, 32'h02);
    reg_wr(A_STAT, 32'hFF);
    reg_wr(A_BYTE, 32'h00);
    reg_wr(A_CMD, 32'h2);
    m_read_byte(data);
    chk("R8 no data after nak", {24'b0, data}, 32'hFF);
    m_stop();
    reg_rd(A_STAT, rd);
    chk("R9 stop after read", rd, 32'h10);
    reg_wr(A_STAT, 32'hFF);

    // R9: idle after stop, a fresh matching address is needed again
    m_start();
    m_write_byte({OWN ^ 7'h01, 1'b0}, 1'b0, ack_n);
    m_stop();
    chk("R9 idle after stop ignores other address", {31'b0, ack_n}, 32'h1);
    finish_run();
  end
endmodule